// File: doc/BRIEF.md
# General-Purpose I/O Port Register Block

This block is the register front end of a 16-pin general-purpose I/O port. A simple single-cycle register bus reaches six word registers:
- two pin configuration words
- an input level word
- an output data word
- an atomic set/clear word
- a clear-only word

Each pin has its own 4-bit configuration field. The field decodes into pad control signals:
- output enable
- open-drain select
- alternate-function select
- pull enable and pull direction

The output data word drives the pad output levels. In pull mode it also picks the pull direction.

Pad input levels pass through a two-flop synchronizer before they can be read. Software can change output bits atomically through the set/clear word, with no read-modify-write. A per-pin lock input write-protects configuration fields. Reads return data combinationally for the current address. Writes take effect at the clock edge where the write strobe is high.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset every configuration field holds 0x4, so both configuration words (addresses 0 and 1) read 0x44444444. The output data word reads 0, and every pad control output is 0.
- R2: A pin's field has MODE in bits [1:0] and CNF in bits [3:2]. Pin n sits at bits [4n+3:4n] of address 0 for n<8, and at bits [4(n-8)+3:4(n-8)] of address 1 for n≥8. Written fields read back unchanged.
- R3: With MODE=00 the pin is an input and drives nothing. CNF=10 raises pull enable. CNF=00 (analog), 01 (floating) and 11 leave pull enable low.
- R4: With MODE≠00 the output enable is high. Open-drain select equals CNF[0]. Alternate-function select equals CNF[1]. Pull enable is low.
- R5: The pull-up output is high only for a pin with pull enabled whose output data bit is 1. A pulled pin with output data 0 is pulled down.
- R6: A write to address 4 sets the output data bits marked in bits [15:0] and clears those marked in bits [31:16], both at the same clock edge. Address 4 reads 0.
- R7: A pin marked in both halves of an address-4 write ends up set.
- R8: A write to address 5 clears the output data bits marked in bits [15:0]. Bits [31:16] are ignored, and address 5 reads 0.
- R9: A write to address 3 loads the output data word from bits [15:0]. Reads of address 3 return it in bits [15:0] with zeros above. `out_val_o` equals the output data word.
- R10: Address 2 returns the pad levels two clock edges after they are applied. After only one edge it still returns the old levels.
- R11: A configuration write leaves the field of any pin whose `lock_i` bit is high unchanged. Unlocked pins in the same word are updated.
- R12: Addresses 6 and 7 read 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe, sampled at the rising edge |
| addr_i | input | 3 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| pad_in_i | input | 16 | Pad input levels (asynchronous) |
| lock_i | input | 16 | Per-pin configuration write protect |
| out_val_o | output | 16 | Pad output levels |
| out_en_o | output | 16 | Pad output enable |
| open_drain_o | output | 16 | Open-drain select |
| alt_fn_o | output | 16 | Alternate-function select |
| pull_en_o | output | 16 | Pull resistor enable |
| pull_up_o | output | 16 | Pull direction, 1 = up |

## Verification
The set and clear halves of one atomic write can land on the same output bit at the same edge. The bench provokes this with an address-4 write that marks one pin in both halves. It judges the result by reading back the output data word and expecting the bit set.

A configuration write can also meet a lock on some pins in the same cycle. The bench holds two pins locked during a full-word write. It then expects the old fields for those two pins and the new fields for the rest, both in the read-back word and in the output-enable pattern.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_W  = 3;
  localparam int REG_W   = 32;
  localparam int FIELD_W = 4;

  typedef logic [ADDR_W-1:0] reg_addr_t;

  localparam reg_addr_t ADDR_CFG_LO = 3'd0;
  localparam reg_addr_t ADDR_CFG_HI = 3'd1;
  localparam reg_addr_t ADDR_IN     = 3'd2;
  localparam reg_addr_t ADDR_OUT    = 3'd3;
  localparam reg_addr_t ADDR_SETCLR = 3'd4;
  localparam reg_addr_t ADDR_CLR    = 3'd5;

  // floating input: MODE=00, CNF=01
  localparam logic [FIELD_W-1:0] CFG_RESET = 4'h4;
  localparam logic [1:0]         CNF_PULL  = 2'b10;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stg_q[s] <= '0;
      end else if (s == 0) begin
        stg_q[s] <= d_i;
      end else begin
        stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_out_data.sv
module gpio_out_data #(
  parameter int WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] load_val_i,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] d;

  // set applied after clear so set wins on overlap
  always_comb begin
    if (load_i) d = load_val_i;
    else        d = (q_o & ~clr_i) | set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d;
  end
endmodule

// File: rtl/gpio_pin_decode.sv
module gpio_pin_decode
  import gpio_pkg::*;
(
  input  logic [FIELD_W-1:0] cfg_i,
  input  logic               odr_i,
  output logic               oe_o,
  output logic               od_o,
  output logic               af_o,
  output logic               pe_o,
  output logic               pu_o
);
  logic [1:0] mode;
  logic [1:0] cnf;
  logic       is_out;

  assign mode   = cfg_i[1:0];
  assign cnf    = cfg_i[3:2];
  assign is_out = |mode;

  assign oe_o = is_out;
  assign od_o = is_out & cnf[0];
  assign af_o = is_out & cnf[1];
  assign pe_o = !is_out && (cnf == CNF_PULL);
  assign pu_o = pe_o & odr_i;
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_pkg::*;
#(
  parameter int NUM_PINS = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [REG_W-1:0]    wdata_i,
  output logic [REG_W-1:0]    rdata_o,
  input  logic [NUM_PINS-1:0] pad_in_i,
  input  logic [NUM_PINS-1:0] lock_i,
  output logic [NUM_PINS-1:0] out_val_o,
  output logic [NUM_PINS-1:0] out_en_o,
  output logic [NUM_PINS-1:0] open_drain_o,
  output logic [NUM_PINS-1:0] alt_fn_o,
  output logic [NUM_PINS-1:0] pull_en_o,
  output logic [NUM_PINS-1:0] pull_up_o
);
  localparam int PINS_PER_REG = REG_W / FIELD_W;
  localparam int NUM_CFG_REGS = NUM_PINS / PINS_PER_REG;
  localparam int CLR_HI_LSB   = REG_W / 2;

  logic [NUM_PINS-1:0]           idr_q;
  logic [NUM_PINS-1:0]           odr_q;
  logic [NUM_CFG_REGS*REG_W-1:0] cfg_flat;
  logic                          wr_out, wr_setclr, wr_clr;
  logic [NUM_PINS-1:0]           set_mask, clr_mask;

  assign wr_out    = wr_en_i && (addr_i == ADDR_OUT);
  assign wr_setclr = wr_en_i && (addr_i == ADDR_SETCLR);
  assign wr_clr    = wr_en_i && (addr_i == ADDR_CLR);

  assign set_mask = wr_setclr ? wdata_i[NUM_PINS-1:0] : '0;
  assign clr_mask = wr_setclr ? wdata_i[CLR_HI_LSB +: NUM_PINS] :
                    wr_clr    ? wdata_i[NUM_PINS-1:0] : '0;

  gpio_in_sync #(.WIDTH(NUM_PINS), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_in_i),
    .q_o   (idr_q)
  );

  gpio_out_data #(.WIDTH(NUM_PINS)) u_odr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (wr_out),
    .load_val_i(wdata_i[NUM_PINS-1:0]),
    .set_i     (set_mask),
    .clr_i     (clr_mask),
    .q_o       (odr_q)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam int REG_IDX = p / PINS_PER_REG;
    localparam int BIT_OFF = (p % PINS_PER_REG) * FIELD_W;

    logic               hit;
    logic [FIELD_W-1:0] cfg_q;

    assign hit = wr_en_i && !lock_i[p] &&
                 (addr_i == reg_addr_t'(int'(ADDR_CFG_LO) + REG_IDX));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  cfg_q <= CFG_RESET;
      else if (hit) cfg_q <= wdata_i[BIT_OFF +: FIELD_W];
    end

    assign cfg_flat[p*FIELD_W +: FIELD_W] = cfg_q;

    gpio_pin_decode u_dec (
      .cfg_i(cfg_q),
      .odr_i(odr_q[p]),
      .oe_o (out_en_o[p]),
      .od_o (open_drain_o[p]),
      .af_o (alt_fn_o[p]),
      .pe_o (pull_en_o[p]),
      .pu_o (pull_up_o[p])
    );
  end

  assign out_val_o = odr_q;

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < NUM_CFG_REGS; k++) begin
      if (addr_i == reg_addr_t'(int'(ADDR_CFG_LO) + k)) rdata_o = cfg_flat[k*REG_W +: REG_W];
    end
    if (addr_i == ADDR_IN)  rdata_o[NUM_PINS-1:0] = idr_q;
    if (addr_i == ADDR_OUT) rdata_o[NUM_PINS-1:0] = odr_q;
  end
endmodule

// File: rtl/gpio_port_regs_chk.sv
module gpio_port_regs_chk
  import gpio_pkg::*;
#(
  parameter int NUM_PINS = 16
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                wr_en_i,
  input logic [ADDR_W-1:0]   addr_i,
  input logic [REG_W-1:0]    wdata_i,
  input logic [NUM_PINS-1:0] pad_in_i,
  input logic [NUM_PINS-1:0] lock_i,
  input logic [NUM_PINS-1:0] idr_q,
  input logic [NUM_PINS-1:0] out_val_o,
  input logic [NUM_PINS-1:0] out_en_o,
  input logic [NUM_PINS-1:0] open_drain_o,
  input logic [NUM_PINS-1:0] alt_fn_o,
  input logic [NUM_PINS-1:0] pull_en_o
);
  logic [1:0] run_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             run_cnt <= '0;
    else if (run_cnt != 2'd2) run_cnt <= run_cnt + 2'd1;
  end

  // R6 and R7: set/clear in one edge, set dominant
  assert_setclr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_SETCLR) |=>
      out_val_o == (($past(out_val_o) & ~$past(wdata_i[16 +: NUM_PINS]))
                    | $past(wdata_i[NUM_PINS-1:0])));

  assert_clr_only_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_CLR) |=>
      out_val_o == ($past(out_val_o) & ~$past(wdata_i[NUM_PINS-1:0])));

  assert_out_load_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_OUT) |=> out_val_o == $past(wdata_i[NUM_PINS-1:0]));

  assert_in_sync_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_cnt == 2'd2) |-> idr_q == $past(pad_in_i, 2));

  assert_lock_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (addr_i == ADDR_CFG_LO || addr_i == ADDR_CFG_HI)) |=>
      ((((out_en_o ^ $past(out_en_o)) | (open_drain_o ^ $past(open_drain_o)) |
         (alt_fn_o ^ $past(alt_fn_o)) | (pull_en_o ^ $past(pull_en_o)))
        & $past(lock_i)) == '0));
endmodule

bind gpio_port_regs gpio_port_regs_chk #(.NUM_PINS(NUM_PINS)) u_chk (.*);

// File: tb/gpio_port_regs_tb.sv
`timescale 1ns/1ps
module gpio_port_regs_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [15:0] pad_in_i = '0;
  logic [15:0] lock_i = '0;
  logic [15:0] out_val_o, out_en_o, open_drain_o, alt_fn_o, pull_en_o, pull_up_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  gpio_port_regs u_dut (.*);

  // {req, we, addr, wdata, expected read}
  localparam int NV = 19;
  localparam logic [71:0] VEC [NV] = '{
    {4'd9,  1'b1, 3'd3, 32'h0000_00F0, 32'h0},
    {4'd9,  1'b0, 3'd3, 32'h0,         32'h0000_00F0},
    {4'd6,  1'b1, 3'd4, 32'h00F0_0F00, 32'h0},          // R6 set+clear
    {4'd6,  1'b0, 3'd3, 32'h0,         32'h0000_0F00},
    {4'd7,  1'b1, 3'd4, 32'h0100_0100, 32'h0},          // R7 same pin both halves
    {4'd7,  1'b0, 3'd3, 32'h0,         32'h0000_0F00},
    {4'd6,  1'b0, 3'd4, 32'h0,         32'h0},
    {4'd8,  1'b1, 3'd5, 32'hFFFF_0300, 32'h0},          // R8 upper half ignored
    {4'd8,  1'b0, 3'd3, 32'h0,         32'h0000_0C00},
    {4'd8,  1'b0, 3'd5, 32'h0,         32'h0},
    {4'd9,  1'b1, 3'd3, 32'hFFFF_1234, 32'h0},
    {4'd9,  1'b0, 3'd3, 32'h0,         32'h0000_1234},
    {4'd12, 1'b1, 3'd6, 32'hFFFF_FFFF, 32'h0},          // R12 unmapped write
    {4'd12, 1'b0, 3'd3, 32'h0,         32'h0000_1234},
    {4'd12, 1'b0, 3'd6, 32'h0,         32'h0},
    {4'd2,  1'b1, 3'd0, 32'h8765_4321, 32'h0},          // R2 placement
    {4'd2,  1'b0, 3'd0, 32'h0,         32'h8765_4321},
    {4'd2,  1'b1, 3'd1, 32'h0000_FFFF, 32'h0},
    {4'd2,  1'b0, 3'd1, 32'h0,         32'h0000_FFFF}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input string req, input logic [31:0] exp);
    addr_i = a;
    #0.5;
    check(req, rdata_o, exp);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    rd(3'd0, "R1 cfg lo", 32'h4444_4444);
    rd(3'd1, "R1 cfg hi", 32'h4444_4444);
    rd(3'd3, "R1 out", 32'h0);
    check("R1 out_en", {16'h0, out_en_o}, 32'h0);
    check("R1 pull_en", {16'h0, pull_en_o | pull_up_o | out_val_o}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [71:0] v;
      v = VEC[i];
      if (v[67]) wr(v[66:64], v[63:32]);
      else       rd(v[66:64], $sformatf("R%0d vec %0d", v[71:68], i), v[31:0]);
    end

    // R3 R4 decode: pins 0..7 = 0,4,8,C,1,6,B,F
    wr(3'd1, 32'h4444_4444);
    wr(3'd0, 32'hFB61_C840);
    check("R4 out_en", {16'h0, out_en_o}, 32'h0000_00F0);
    check("R4 open_drain", {16'h0, open_drain_o}, 32'h0000_00A0);
    check("R4 alt_fn", {16'h0, alt_fn_o}, 32'h0000_00C0);
    check("R3 pull_en", {16'h0, pull_en_o}, 32'h0000_0004);

    // R5 pull direction from output data bit
    wr(3'd4, 32'h0004_0000);
    check("R5 pull down", {16'h0, pull_up_o}, 32'h0);
    wr(3'd4, 32'h0000_0004);
    check("R5 pull up", {16'h0, pull_up_o}, 32'h0000_0004);
    check("R9 out_val", {16'h0, out_val_o}, 32'h0000_1234);

    // R11 lock pins 0 and 1
    lock_i = 16'h0003;
    wr(3'd0, 32'h1111_1111);
    lock_i = 16'h0000;
    rd(3'd0, "R11 locked fields", 32'h1111_1140);
    check("R11 out_en", {16'h0, out_en_o}, 32'h0000_00FC);
    wr(3'd0, 32'h4444_4444);
    rd(3'd0, "R11 unlocked", 32'h4444_4444);

    // R10 two-edge synchronizer
    @(negedge clk_i);
    pad_in_i = 16'hA5A5;
    @(negedge clk_i);
    rd(3'd2, "R10 one edge", 32'h0);
    @(negedge clk_i);
    rd(3'd2, "R10 two edges", 32'h0000_A5A5);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule